// File: doc/BRIEF.md
# Double-Buffered PWM Comparison Update Unit

This block is one comparison unit that watches the counter of a reference PWM channel. It holds an active comparison value and an active configuration: a compare enable and an update period. It also holds an update-period counter that steps once per reference period. A host can rewrite the comparison value and the configuration at any time while the channel runs. The writes go into shadow registers. The unit moves them into the active registers only at a safe boundary: the end of a reference period on which the update-period counter sits at its programmed terminal value.

A value write alone is only held. It is staged for commit only when a configuration write follows it. The unit raises a one-cycle match pulse when the counter reaches the active value, and a one-cycle update pulse when a commit happens. Each event also sets a sticky status flag. A status read clears the flags. An interrupt line combines the flags, each gated by a mask bit.

The shadow sequencing is a six-state machine:
- SH_IDLE: nothing staged.
- SH_HELD: a value has been written and is waiting for its configuration write.
- SH_ARM_CFG: a configuration is staged without a value.
- SH_ARM_BOTH: a configuration is staged with a value.
- SH_ARM_CFG_HELD and SH_ARM_BOTH_HELD: the matching armed states that also hold a newer value, still waiting for a configuration write.

A commit moves any armed state to SH_HELD if a value is held, and to SH_IDLE otherwise. A value write moves SH_IDLE to SH_HELD, SH_ARM_CFG to SH_ARM_CFG_HELD and SH_ARM_BOTH to SH_ARM_BOTH_HELD. A configuration write moves SH_IDLE to SH_ARM_CFG. From SH_HELD, SH_ARM_CFG_HELD or SH_ARM_BOTH_HELD it moves to SH_ARM_BOTH. SH_ARM_CFG and SH_ARM_BOTH stay where they are on a configuration write. In a cycle with both a commit and a write, the commit applies first and the write then acts on the resulting state.

Top module: `pwm_cmp_shadow`

## Requirements
- R1: After reset the active value, enable, update period and update-period counter are 0. The status flags and both mask bits are 0, and no pulse or interrupt is raised.
- R2: A staged set is copied into the active registers on a clock edge where ref_period_end is 1, upr_cnt equals act_upr and a configuration write is pending. The new active values are visible from the next cycle. Active registers change at no other edge.
- R3: A write with wr_addr=0 loads the shadow value from wr_data. On its own it never reaches act_value. It is staged only by a later configuration write.
- R4: A write with wr_addr=1 loads the shadow configuration: enable from wr_data[0] and update period from wr_data[UPR_W:1]. If no value write came before it since the previous staging, the commit changes only the configuration and act_value keeps its value.
- R5: When the shadow value or the shadow configuration is written several times before staging or commit, only the last write is applied.
- R6: At each edge with ref_period_end=1, upr_cnt wraps to 0 if it equals act_upr (the pre-commit value) and otherwise increments. Without ref_period_end it holds.
- R7: upd_pulse is 1 for exactly the cycle after a commit edge, and the same edge sets status bit 1 (update flag).
- R8: When act_enable is 1 and ref_cnt equals act_value, the first cycle of that equality gives match_pulse=1 in the following cycle only. The same edge sets status bit 0 (match flag).
- R9: A status flag stays 1 until an edge with stat_rd=1 clears it. An event at that same edge leaves its flag set.
- R10: irq is 1 when a set flag has its mask bit set (bit 0 match, bit 1 update). A write with wr_addr=2 sets the mask bits that are 1 in wr_data[1:0]. A write with wr_addr=3 clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 shadow value, 1 shadow configuration, 2 mask set, 3 mask clear |
| wr_data | input | CNT_W | Write data |
| stat_rd | input | 1 | Status read; clears the flags |
| ref_cnt | input | CNT_W | Reference channel counter |
| ref_period_end | input | 1 | Reference channel is at the end of its period |
| match_pulse | output | 1 | One-cycle comparison match pulse |
| upd_pulse | output | 1 | One-cycle commit pulse |
| irq | output | 1 | Masked OR of the status flags |
| stat_flags | output | 2 | Bit 0 match flag, bit 1 update flag |
| act_value | output | CNT_W | Active comparison value |
| act_enable | output | 1 | Active compare enable |
| act_upr | output | UPR_W | Active update period |
| upr_cnt | output | UPR_W | Update-period counter |

## Verification
Active registers, upd_pulse and the update flag all change the cycle after the edge that samples the commit condition. match_pulse and the match flag rise the cycle after the first cycle in which ref_cnt equals the active value. irq follows the flags and mask with no extra register, and a status read shows cleared flags from the next cycle. The bench drives every input at the falling edge, advances its reference model for the coming rising edge, and compares all outputs at the next falling edge. Every expected value is therefore due exactly one edge after its stimulus.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

    typedef enum logic [2:0] {
        SH_IDLE,
        SH_HELD,
        SH_ARM_CFG,
        SH_ARM_BOTH,
        SH_ARM_CFG_HELD,
        SH_ARM_BOTH_HELD
    } shadow_state_e;

    localparam logic [1:0] ADDR_VAL  = 2'd0;
    localparam logic [1:0] ADDR_CFG  = 2'd1;
    localparam logic [1:0] ADDR_IEN  = 2'd2;
    localparam logic [1:0] ADDR_IDIS = 2'd3;

    localparam int FLAG_MATCH = 0;
    localparam int FLAG_UPD   = 1;
    localparam int NUM_FLAGS  = 2;

endpackage

// File: rtl/pcu_period_ctr.sv
module pcu_period_ctr #(
    parameter int UPR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             period_end_i,
    input  logic [UPR_W-1:0] upr_i,
    output logic [UPR_W-1:0] cnt_o,
    output logic             boundary_o
);

    logic [UPR_W-1:0] cnt_q;
    logic             at_top;

    always_comb begin
        at_top     = (cnt_q == upr_i);
        boundary_o = period_end_i && at_top;
        cnt_o      = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (period_end_i) begin
            if (at_top) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R6
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !period_end_i |=> $stable(cnt_q));

    // R6
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= upr_i);

endmodule

// File: rtl/pcu_shadow_fsm.sv
module pcu_shadow_fsm
    import pcu_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int UPR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_val_i,
    input  logic             wr_cfg_i,
    input  logic [CNT_W-1:0] val_data_i,
    input  logic [UPR_W:0]   cfg_data_i,
    input  logic             boundary_i,
    output logic [CNT_W-1:0] act_val_o,
    output logic             act_en_o,
    output logic [UPR_W-1:0] act_upr_o,
    output logic             commit_o
);

    shadow_state_e state_q, state_d, base_s;

    logic [CNT_W-1:0] sh_val_q;
    logic [CNT_W-1:0] stg_val_q;
    logic             stg_en_q;
    logic [UPR_W-1:0] stg_upr_q;
    logic [CNT_W-1:0] act_val_q;
    logic             act_en_q;
    logic [UPR_W-1:0] act_upr_q;

    logic armed, carry_val, held, commit;

    // Decode of the current state
    always_comb begin
        armed     = (state_q == SH_ARM_CFG) || (state_q == SH_ARM_BOTH) ||
                    (state_q == SH_ARM_CFG_HELD) || (state_q == SH_ARM_BOTH_HELD);
        carry_val = (state_q == SH_ARM_BOTH) || (state_q == SH_ARM_BOTH_HELD);
        held      = (state_q == SH_HELD) || (state_q == SH_ARM_CFG_HELD) ||
                    (state_q == SH_ARM_BOTH_HELD);
        commit    = boundary_i && armed;
    end

    // Next state: commit first, then the write of this cycle
    always_comb begin
        if (commit) begin
            base_s = held ? SH_HELD : SH_IDLE;
        end else begin
            base_s = state_q;
        end
        state_d = base_s;
        if (wr_val_i) begin
            unique case (base_s)
                SH_IDLE:          state_d = SH_HELD;
                SH_HELD:          state_d = SH_HELD;
                SH_ARM_CFG:       state_d = SH_ARM_CFG_HELD;
                SH_ARM_BOTH:      state_d = SH_ARM_BOTH_HELD;
                SH_ARM_CFG_HELD:  state_d = SH_ARM_CFG_HELD;
                SH_ARM_BOTH_HELD: state_d = SH_ARM_BOTH_HELD;
                default:          state_d = SH_IDLE;
            endcase
        end else if (wr_cfg_i) begin
            unique case (base_s)
                SH_IDLE:          state_d = SH_ARM_CFG;
                SH_HELD:          state_d = SH_ARM_BOTH;
                SH_ARM_CFG:       state_d = SH_ARM_CFG;
                SH_ARM_BOTH:      state_d = SH_ARM_BOTH;
                SH_ARM_CFG_HELD:  state_d = SH_ARM_BOTH;
                SH_ARM_BOTH_HELD: state_d = SH_ARM_BOTH;
                default:          state_d = SH_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SH_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Shadow, staging and active registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_val_q  <= '0;
            stg_val_q <= '0;
            stg_en_q  <= 1'b0;
            stg_upr_q <= '0;
            act_val_q <= '0;
            act_en_q  <= 1'b0;
            act_upr_q <= '0;
        end else begin
            if (wr_val_i) begin
                sh_val_q <= val_data_i;
            end
            if (wr_cfg_i) begin
                stg_en_q  <= cfg_data_i[0];
                stg_upr_q <= cfg_data_i[UPR_W:1];
                if (held) begin
                    stg_val_q <= sh_val_q;
                end
            end
            if (commit) begin
                act_en_q  <= stg_en_q;
                act_upr_q <= stg_upr_q;
                if (carry_val) begin
                    act_val_q <= stg_val_q;
                end
            end
        end
    end

    always_comb begin
        act_val_o = act_val_q;
        act_en_o  = act_en_q;
        act_upr_o = act_upr_q;
        commit_o  = commit;
    end

    // R2
    act_val_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_val_q) |-> $past(boundary_i));

    // R2
    act_cfg_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_upr_q) |-> $past(boundary_i));

    // R3
    held_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SH_HELD) |=> $stable(act_val_q));

endmodule

// File: rtl/pcu_match_det.sv
module pcu_match_det #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [CNT_W-1:0] val_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             event_o,
    output logic             pulse_o
);

    logic eq, eq_prev_q, pulse_q;

    always_comb begin
        eq      = en_i && (cnt_i == val_i);
        event_o = eq && !eq_prev_q;
        pulse_o = pulse_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eq_prev_q <= 1'b0;
            pulse_q   <= 1'b0;
        end else begin
            eq_prev_q <= eq;
            pulse_q   <= event_o;
        end
    end

    // R8
    match_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |=> !pulse_q);

endmodule

// File: rtl/pcu_irq_flags.sv
module pcu_irq_flags
    import pcu_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ev_match_i,
    input  logic                 ev_upd_i,
    input  logic                 rd_i,
    input  logic [NUM_FLAGS-1:0] mask_set_i,
    input  logic [NUM_FLAGS-1:0] mask_clr_i,
    output logic [NUM_FLAGS-1:0] flags_o,
    output logic                 irq_o
);

    logic [NUM_FLAGS-1:0] flags_q, mask_q, events;

    always_comb begin
        events             = '0;
        events[FLAG_MATCH] = ev_match_i;
        events[FLAG_UPD]   = ev_upd_i;
    end

    genvar gi;
    generate
        for (gi = 0; gi < NUM_FLAGS; gi++) begin : g_flag
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    flags_q[gi] <= 1'b0;
                    mask_q[gi]  <= 1'b0;
                end else begin
                    flags_q[gi] <= events[gi] || (flags_q[gi] && !rd_i);
                    if (mask_set_i[gi]) begin
                        mask_q[gi] <= 1'b1;
                    end else if (mask_clr_i[gi]) begin
                        mask_q[gi] <= 1'b0;
                    end
                end
            end

            // R9
            flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (flags_q[gi] && !rd_i) |=> flags_q[gi]);

            // R9
            flag_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
                events[gi] |=> flags_q[gi]);
        end
    endgenerate

    always_comb begin
        flags_o = flags_q;
        irq_o   = |(flags_q & mask_q);
    end

endmodule

// File: rtl/pwm_cmp_shadow.sv
module pwm_cmp_shadow
    import pcu_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int UPR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             stat_rd,
    input  logic [CNT_W-1:0] ref_cnt,
    input  logic             ref_period_end,
    output logic             match_pulse,
    output logic             upd_pulse,
    output logic             irq,
    output logic [1:0]       stat_flags,
    output logic [CNT_W-1:0] act_value,
    output logic             act_enable,
    output logic [UPR_W-1:0] act_upr,
    output logic [UPR_W-1:0] upr_cnt
);

    localparam int CFG_W = UPR_W + 1;

    logic                 wr_val, wr_cfg;
    logic [NUM_FLAGS-1:0] mask_set, mask_clr;
    logic                 boundary, commit, match_ev, upd_q;

    always_comb begin
        wr_val   = wr_en && (wr_addr == ADDR_VAL);
        wr_cfg   = wr_en && (wr_addr == ADDR_CFG);
        mask_set = (wr_en && (wr_addr == ADDR_IEN))  ? wr_data[NUM_FLAGS-1:0] : '0;
        mask_clr = (wr_en && (wr_addr == ADDR_IDIS)) ? wr_data[NUM_FLAGS-1:0] : '0;
    end

    pcu_period_ctr #(.UPR_W(UPR_W)) u_ctr (
        .clk          (clk),
        .rst_n        (rst_n),
        .period_end_i (ref_period_end),
        .upr_i        (act_upr),
        .cnt_o        (upr_cnt),
        .boundary_o   (boundary)
    );

    pcu_shadow_fsm #(.CNT_W(CNT_W), .UPR_W(UPR_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_val_i   (wr_val),
        .wr_cfg_i   (wr_cfg),
        .val_data_i (wr_data),
        .cfg_data_i (wr_data[CFG_W-1:0]),
        .boundary_i (boundary),
        .act_val_o  (act_value),
        .act_en_o   (act_enable),
        .act_upr_o  (act_upr),
        .commit_o   (commit)
    );

    pcu_match_det #(.CNT_W(CNT_W)) u_match (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (act_enable),
        .val_i   (act_value),
        .cnt_i   (ref_cnt),
        .event_o (match_ev),
        .pulse_o (match_pulse)
    );

    pcu_irq_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_match_i (match_ev),
        .ev_upd_i   (commit),
        .rd_i       (stat_rd),
        .mask_set_i (mask_set),
        .mask_clr_i (mask_clr),
        .flags_o    (stat_flags),
        .irq_o      (irq)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_q <= 1'b0;
        end else begin
            upd_q <= commit;
        end
    end

    assign upd_pulse = upd_q;

    // R7
    upd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_q |=> !upd_q);

    // R7
    upd_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_q |-> stat_flags[FLAG_UPD]);

endmodule

// File: tb/sim_pwm_cmp_shadow.sv
module sim_pwm_cmp_shadow;

    localparam int CLK_PERIOD = 10;
    localparam int CW  = 16;
    localparam int UW  = 4;
    localparam int PER = 6;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          wr_en;
    logic [1:0]    wr_addr;
    logic [CW-1:0] wr_data;
    logic          stat_rd;
    logic [CW-1:0] ref_cnt;
    logic          ref_period_end;
    logic          match_pulse, upd_pulse, irq;
    logic [1:0]    stat_flags;
    logic [CW-1:0] act_value;
    logic          act_enable;
    logic [UW-1:0] act_upr, upr_cnt;

    pwm_cmp_shadow #(.CNT_W(CW), .UPR_W(UW)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .stat_rd(stat_rd), .ref_cnt(ref_cnt),
        .ref_period_end(ref_period_end), .match_pulse(match_pulse),
        .upd_pulse(upd_pulse), .irq(irq), .stat_flags(stat_flags),
        .act_value(act_value), .act_enable(act_enable), .act_upr(act_upr),
        .upr_cnt(upr_cnt)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 0;
    int  rc    = 0;

    // reference model state
    logic [CW-1:0] m_sv, m_stv, m_av;
    logic          m_sten, m_aen;
    logic [UW-1:0] m_stupr, m_aupr, m_uc;
    bit            m_vh, m_arm, m_hv, m_eqp, m_mp, m_up, m_fm, m_fu;
    bit   [1:0]    m_mask;

    function automatic bit exp_irq();
        return (m_fm && m_mask[0]) || (m_fu && m_mask[1]);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_sv = '0; m_stv = '0; m_av = '0; m_sten = 0; m_aen = 0;
        m_stupr = '0; m_aupr = '0; m_uc = '0;
        m_vh = 0; m_arm = 0; m_hv = 0; m_eqp = 0; m_mp = 0; m_up = 0;
        m_fm = 0; m_fu = 0; m_mask = '0;
    endtask

    task automatic model_tick(input bit we, input logic [1:0] a,
                              input logic [CW-1:0] d, input bit rd);
        bit pe, eq, evm, com, vh, arm, hv;
        logic [UW-1:0] nuc;
        pe  = (rc == PER - 1);
        eq  = m_aen && (CW'(rc) == m_av);
        evm = eq && !m_eqp;
        com = pe && (m_uc == m_aupr) && m_arm;
        nuc = pe ? ((m_uc == m_aupr) ? '0 : m_uc + 1'b1) : m_uc;
        vh = m_vh; arm = m_arm; hv = m_hv;
        if (com) begin
            m_aen  = m_sten;
            m_aupr = m_stupr;
            if (m_hv) m_av = m_stv;
            arm = 0;
            hv  = 0;
        end
        if (we) begin
            case (a)
                2'd0: begin m_sv = d; vh = 1; end
                2'd1: begin
                    m_sten  = d[0];
                    m_stupr = d[UW:1];
                    if (vh) begin
                        m_stv = m_sv; hv = 1; vh = 0;
                    end else if (!arm) begin
                        hv = 0;
                    end
                    arm = 1;
                end
                2'd2: m_mask = m_mask | d[1:0];
                default: m_mask = m_mask & ~d[1:0];
            endcase
        end
        m_vh = vh; m_arm = arm; m_hv = hv; m_uc = nuc;
        m_eqp = eq; m_mp = evm; m_up = com;
        m_fm = evm || (m_fm && !rd);
        m_fu = com || (m_fu && !rd);
    endtask

    task automatic compare();
        chk(act_value == m_av, "R2", "act_value", int'(act_value), int'(m_av));
        chk(act_enable == m_aen, "R2", "act_enable", int'(act_enable), int'(m_aen));
        chk(act_upr == m_aupr, "R4", "act_upr", int'(act_upr), int'(m_aupr));
        chk(upr_cnt == m_uc, "R6", "upr_cnt", int'(upr_cnt), int'(m_uc));
        chk(match_pulse == m_mp, "R8", "match_pulse", int'(match_pulse), int'(m_mp));
        chk(upd_pulse == m_up, "R7", "upd_pulse", int'(upd_pulse), int'(m_up));
        chk(stat_flags == {m_fu, m_fm}, "R9", "stat_flags", int'(stat_flags),
            int'({m_fu, m_fm}));
        chk(irq == exp_irq(), "R10", "irq", int'(irq), int'(exp_irq()));
    endtask

    // drive at falling edge, advance model, compare at next falling edge
    task automatic step(input bit we, input logic [1:0] a,
                        input logic [CW-1:0] d, input bit rd);
        wr_en = we; wr_addr = a; wr_data = d; stat_rd = rd;
        ref_cnt = CW'(rc);
        ref_period_end = (rc == PER - 1);
        model_tick(we, a, d, rd);
        @(posedge clk);
        @(negedge clk);
        rc = (rc == PER - 1) ? 0 : rc + 1;
        compare();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 2'd0, '0, 0);
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog (all requirements): actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 0; wr_en = 0; wr_addr = '0; wr_data = '0; stat_rd = 0;
        ref_cnt = '0; ref_period_end = 0;
        model_reset();
        repeat (4) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        chk(act_value == 0 && act_enable == 0 && act_upr == 0, "R1", "active regs",
            int'(act_value), 0);
        chk(upr_cnt == 0 && stat_flags == 0, "R1", "counter/flags",
            int'({upr_cnt, stat_flags}), 0);
        chk(!match_pulse && !upd_pulse && !irq, "R1", "pulses/irq",
            int'({match_pulse, upd_pulse, irq}), 0);

        // R3: value write alone never commits
        step(1, 2'd0, CW'(3), 0);
        idle(40);
        chk(act_value == 0, "R3", "value-only write", int'(act_value), 0);

        // R2: config write stages the held value; commit at boundary
        step(1, 2'd1, CW'(3), 0);
        idle(40);
        chk(act_value == 3 && act_enable == 1 && act_upr == 1, "R2", "commit pair",
            int'({act_value, act_enable, act_upr}), int'({CW'(3), 1'b1, UW'(1)}));

        // R4: config-only commit keeps the value
        step(1, 2'd1, CW'(1), 0);
        idle(40);
        chk(act_value == 3 && act_upr == 0, "R4", "config-only commit",
            int'({act_value, act_upr}), int'({CW'(3), UW'(0)}));

        // R5: last writes win
        step(1, 2'd0, CW'(1), 0);
        step(1, 2'd0, CW'(4), 0);
        step(1, 2'd1, CW'(5), 0);
        step(1, 2'd1, CW'(1), 0);
        idle(20);
        chk(act_value == 4 && act_upr == 0, "R5", "last write applied",
            int'({act_value, act_upr}), int'({CW'(4), UW'(0)}));

        // R10 / R9: enable both masks, watch flags and reads
        step(1, 2'd2, CW'(3), 0);
        idle(12);
        chk(irq == 1, "R10", "irq with mask set", int'(irq), 1);
        step(0, 2'd0, '0, 1);
        step(1, 2'd3, CW'(1), 0);
        idle(12);

        // constrained random mix
        for (int i = 0; i < 4000; i++) begin
            int sel;
            bit rd;
            logic [CW-1:0] d;
            sel = int'($urandom % 16);
            rd  = ($urandom % 8) == 0;
            if (sel < 2) begin
                d = CW'($urandom % (PER + 2));
                step(1, 2'd0, d, rd);
            end else if (sel == 2) begin
                d = CW'((($urandom % 4) << 1) | (($urandom % 4) != 0 ? 1 : 0));
                step(1, 2'd1, d, rd);
            end else if (sel == 3) begin
                step(1, 2'd2, CW'($urandom % 4), rd);
            end else if (sel == 4) begin
                step(1, 2'd3, CW'($urandom % 4), rd);
            end else begin
                step(0, 2'd0, '0, rd);
            end
        end

        done = 1;
        summary();
        $finish;
    end

endmodule